// File: doc/BRIEF.md
# Convertible J-K Registered I/O Bank

A bank of registered I/O cells sitting between a product-term array and a set of bidirectional pins. Each cell holds one rising-edge flip-flop whose J and K inputs come from array terms. A per-cell mode term turns it into a D flip-flop by replacing K with the inverse of J. A per-cell load term captures the value on the pin instead, so the cell works as an input register on a bidirectional bus.

Bank-wide asynchronous clear and preset terms override the clock. The power-on reset puts every register at 1. The pin driver is three-state. Its enable comes either from per-cell select lines or from one shared active-low enable pin, and load always forces it off. The register state always goes back to the array, whatever the enable is doing.

Top module: `regio_bank`

## Requirements
- R1: While `rst_ni` is low, every register bit on `fb_o` is 1, whether or not a clock edge arrives.
- R2: On a rising clock edge with load and D mode off, each bit follows J-K rules. J=0 K=0 holds. J=1 K=0 gives 1. J=0 K=1 gives 0. J=1 K=1 inverts the bit.
- R3: With `d_mode_i[i]`=1 and load off, bit i takes the value of `j_i[i]` on the rising edge, and `k_i[i]` has no effect.
- R4: With `load_i[i]`=1, bit i takes `pad_i[i]` on the rising edge, regardless of J, K and D mode.
- R5: Raising `aclr_i` drives every register bit to 0 at once, without a clock edge.
- R6: Raising `aset_i` drives every register bit to 1 at once, without a clock edge.
- R7: When `aclr_i` and `aset_i` are both high, the registers are 0.
- R8: With `oe_use_pin_i`=0 and load off, `pad_oe_o[i]` equals `oe_sel_i[i]`.
- R9: With `oe_use_pin_i`=1 and load off, every `pad_oe_o` bit equals the inverse of `oe_pin_ni`, and `oe_sel_i` has no effect.
- R10: While `load_i[i]`=1, `pad_oe_o[i]` is 0.
- R11: `fb_o` and `pad_o` always both carry the register state, including when the driver is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous power-on reset, active low, registers to 1 |
| aclr_i | input | 1 | Asynchronous clear term for the bank |
| aset_i | input | 1 | Asynchronous preset term for the bank |
| j_i | input | N_CELLS | J terms, one per cell |
| k_i | input | N_CELLS | K terms, one per cell |
| d_mode_i | input | N_CELLS | Fold-back control: K becomes the inverse of J |
| load_i | input | N_CELLS | Capture the pin value into the register |
| pad_i | input | N_CELLS | Value seen on the pins |
| oe_sel_i | input | N_CELLS | Per-cell output-select enable lines |
| oe_use_pin_i | input | 1 | Enable source: 1 = shared pin, 0 = select lines |
| oe_pin_ni | input | 1 | Shared output enable, active low |
| pad_o | output | N_CELLS | Data driven toward the pins |
| pad_oe_o | output | N_CELLS | Driver enables, active high |
| fb_o | output | N_CELLS | Register feedback to the array |

## Verification
The bench drives mixed J-K patterns so that every cell sees hold, set, clear and toggle. A design that mixed up the clear and set encodings, or that held instead of toggling, would leave wrong bits in the byte. D mode is driven with a K term that contradicts J, which exposes a design that still reads K. Load is driven while J, K and D mode all ask for something else, which catches wrong priority, and the same test checks that the driver is off during load. Asynchronous pulses are placed between clock edges, so a clear or preset that waited for the clock would miss them. Driving both at once catches a design where preset wins. The enable tests switch between the two sources with contradicting select values, and keep the feedback checked while the drivers are off.

// File: rtl/regio_pkg.sv
package regio_pkg;
  typedef enum logic [1:0] {
    FF_JK   = 2'd0,
    FF_D    = 2'd1,
    FF_LOAD = 2'd2
  } ff_mode_e;

  function automatic logic jk_next(input logic q, input logic j, input logic k);
    return (j & ~q) | (~k & q);
  endfunction
endpackage

// File: rtl/regio_cell.sv
module regio_cell
  import regio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclr_i,
  input  logic aset_i,
  input  logic j_i,
  input  logic k_i,
  input  logic d_mode_i,
  input  logic load_i,
  input  logic pad_i,
  input  logic oe_req_i,
  output logic q_o,
  output logic oe_o
);
  ff_mode_e mode;
  logic     k_eff;
  logic     q_d;
  logic     q_r;

  always_comb begin
    if (load_i)        mode = FF_LOAD;
    else if (d_mode_i) mode = FF_D;
    else               mode = FF_JK;
  end

  // fold-back: K replaced by inverted J
  assign k_eff = (mode == FF_D) ? ~j_i : k_i;

  always_comb begin
    unique case (mode)
      FF_LOAD: q_d = pad_i;
      default: q_d = jk_next(q_r, j_i, k_eff);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge aclr_i or posedge aset_i) begin
    if (!rst_ni)     q_r <= 1'b1;
    else if (aclr_i) q_r <= 1'b0;
    else if (aset_i) q_r <= 1'b1;
    else             q_r <= q_d;
  end

  assign q_o  = q_r;
  assign oe_o = oe_req_i & ~load_i;
endmodule

// File: rtl/regio_oe_mux.sv
module regio_oe_mux #(
  parameter int unsigned N_CELLS = 8
) (
  input  logic [N_CELLS-1:0] oe_sel_i,
  input  logic               oe_use_pin_i,
  input  logic               oe_pin_ni,
  output logic [N_CELLS-1:0] oe_req_o
);
  assign oe_req_o = oe_use_pin_i ? {N_CELLS{~oe_pin_ni}} : oe_sel_i;
endmodule

// File: rtl/regio_bank.sv
module regio_bank #(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               aclr_i,
  input  logic               aset_i,
  input  logic [N_CELLS-1:0] j_i,
  input  logic [N_CELLS-1:0] k_i,
  input  logic [N_CELLS-1:0] d_mode_i,
  input  logic [N_CELLS-1:0] load_i,
  input  logic [N_CELLS-1:0] pad_i,
  input  logic [N_CELLS-1:0] oe_sel_i,
  input  logic               oe_use_pin_i,
  input  logic               oe_pin_ni,
  output logic [N_CELLS-1:0] pad_o,
  output logic [N_CELLS-1:0] pad_oe_o,
  output logic [N_CELLS-1:0] fb_o
);
  logic [N_CELLS-1:0] oe_req;
  logic [N_CELLS-1:0] q;

  regio_oe_mux #(.N_CELLS(N_CELLS)) u_oe (
    .oe_sel_i     (oe_sel_i),
    .oe_use_pin_i (oe_use_pin_i),
    .oe_pin_ni    (oe_pin_ni),
    .oe_req_o     (oe_req)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    regio_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .aclr_i   (aclr_i),
      .aset_i   (aset_i),
      .j_i      (j_i[i]),
      .k_i      (k_i[i]),
      .d_mode_i (d_mode_i[i]),
      .load_i   (load_i[i]),
      .pad_i    (pad_i[i]),
      .oe_req_i (oe_req[i]),
      .q_o      (q[i]),
      .oe_o     (pad_oe_o[i])
    );
  end

  assign pad_o = q;
  assign fb_o  = q;
endmodule

// File: rtl/regio_bank_chk.sv
module regio_bank_chk #(
  parameter int unsigned N_CELLS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               aclr_i,
  input logic               aset_i,
  input logic [N_CELLS-1:0] j_i,
  input logic [N_CELLS-1:0] k_i,
  input logic [N_CELLS-1:0] d_mode_i,
  input logic [N_CELLS-1:0] load_i,
  input logic [N_CELLS-1:0] pad_i,
  input logic [N_CELLS-1:0] pad_o,
  input logic [N_CELLS-1:0] pad_oe_o,
  input logic [N_CELLS-1:0] fb_o
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_bit
    assert_toggle_R2: assert property (@(posedge clk_i)
      disable iff (!rst_ni || aclr_i || aset_i)
      (!load_i[i] && !d_mode_i[i] && j_i[i] && k_i[i]) |=> (fb_o[i] == !$past(fb_o[i])));

    assert_dmode_R3: assert property (@(posedge clk_i)
      disable iff (!rst_ni || aclr_i || aset_i)
      (!load_i[i] && d_mode_i[i]) |=> (fb_o[i] == $past(j_i[i])));

    assert_load_R4: assert property (@(posedge clk_i)
      disable iff (!rst_ni || aclr_i || aset_i)
      load_i[i] |=> (fb_o[i] == $past(pad_i[i])));

    assert_load_oe_R10: assert property (@(posedge clk_i)
      disable iff (!rst_ni)
      load_i[i] |-> !pad_oe_o[i]);
  end

  assert_clr_wins_R7: assert property (@(posedge clk_i)
    disable iff (!rst_ni)
    aclr_i |-> (fb_o == '0));

  always_comb begin
    assert_fb_pad_R11: assert (fb_o == pad_o);
  end
endmodule

bind regio_bank regio_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .aclr_i   (aclr_i),
  .aset_i   (aset_i),
  .j_i      (j_i),
  .k_i      (k_i),
  .d_mode_i (d_mode_i),
  .load_i   (load_i),
  .pad_i    (pad_i),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .fb_o     (fb_o)
);

// File: tb/tb_regio_bank.sv
module tb_regio_bank;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         aclr_i = 1'b0, aset_i = 1'b0;
  logic [N-1:0] j_i = '0, k_i = '0, d_mode_i = '0, load_i = '0, pad_i = '0, oe_sel_i = '0;
  logic         oe_use_pin_i = 1'b0, oe_pin_ni = 1'b1;
  logic [N-1:0] pad_o, pad_oe_o, fb_o;

  int compared = 0;
  int mismatched = 0;
  logic [N-1:0] mq = '1;

  string        tag_q[$];
  logic [N-1:0] q_q[$];
  logic [N-1:0] oe_q[$];

  always #10 clk_i = ~clk_i;

  regio_bank #(.N_CELLS(N)) dut (.*);

  task automatic cmp(input string tag, input string what, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: drive in low phase, predict, push after the edge
  task automatic step(input string tag, input logic [N-1:0] j, input logic [N-1:0] k,
                      input logic [N-1:0] d, input logic [N-1:0] ld, input logic [N-1:0] pad,
                      input logic [N-1:0] sel, input logic usepin, input logic oen);
    logic [N-1:0] keff;
    logic [N-1:0] eoe;
    j_i = j; k_i = k; d_mode_i = d; load_i = ld; pad_i = pad;
    oe_sel_i = sel; oe_use_pin_i = usepin; oe_pin_ni = oen;
    keff = (d & ~j) | (~d & k);
    mq   = (ld & pad) | (~ld & ((j & ~mq) | (~keff & mq)));
    eoe  = ~ld & (usepin ? {N{~oen}} : sel);
    @(posedge clk_i);
    tag_q.push_back(tag);
    q_q.push_back(mq);
    oe_q.push_back(eoe);
    @(negedge clk_i);
  endtask

  task automatic async_pulse(input logic clr, input logic set);
    #2;
    aclr_i = clr; aset_i = set;
    #3;
    aclr_i = 1'b0; aset_i = 1'b0;
    if (clr) mq = '0;
    else if (set) mq = '1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      while (tag_q.size() > 0) begin
        string        t;
        logic [N-1:0] eq;
        logic [N-1:0] eo;
        t  = tag_q.pop_front();
        eq = q_q.pop_front();
        eo = oe_q.pop_front();
        cmp(t, "fb_o", fb_o, eq);
        cmp(t, "pad_o", pad_o, eq);
        cmp(t, "pad_oe_o", pad_oe_o, eo);
      end
    end
  end

  initial begin
    #(20 * 20000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #5;
    cmp("R1", "fb_o in reset", fb_o, '1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mq = '1;
    step("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    step("R2", 8'h00, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    step("R2", 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    step("R2", 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    step("R3", 8'hA5, 8'hA5, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    step("R3", 8'h50, 8'hF0, 8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    step("R4", 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h3C, 8'hFF, 1'b0, 1'b1);
    step("R10", 8'h00, 8'hFF, 8'hFF, 8'h81, 8'hFF, 8'hFF, 1'b0, 1'b1);
    step("R8", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 1'b0, 1'b1);
    step("R9", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    step("R11", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1);
    async_pulse(1'b1, 1'b0);
    step("R5", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    async_pulse(1'b0, 1'b1);
    step("R6", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    async_pulse(1'b1, 1'b1);
    step("R7", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    #2 rst_ni = 1'b0;
    #3 rst_ni = 1'b1;
    mq = '1;
    step("R1", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    for (int n = 0; n < 60; n++) begin
      logic [N-1:0] rd, rl;
      rd = N'($urandom);
      rl = N'($urandom) & N'($urandom);
      step("R2", N'($urandom), N'($urandom), rd, rl, N'($urandom), N'($urandom),
           1'($urandom), 1'($urandom));
    end
    repeat (2) @(posedge clk_i);
    #6;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule